// File: doc/BRIEF.md
# Four-Mode Serial Transmitter with Ninth Bit

This block sends one byte per write over a single serial line. A two-bit mode field picks the frame. Mode 0 is a synchronous shifter. It sends eight bits with no framing, and a shift clock comes out beside the data. Mode 1 is an asynchronous frame with eight data bits. Modes 2 and 3 are asynchronous frames with nine bits, where a ninth bit set by software follows the byte. Mode 0 paces bits from the system clock divided by 12. Mode 2 paces them from the system clock divided by 64, or by 32 when the rate-double input is high. Modes 1 and 3 move forward one bit for each pulse on an external rate tick.

The host writes a byte with a one-cycle strobe. The mode, the ninth bit and the rate-double input are captured along with the data. The host then watches the busy output, or the sticky transmit-complete flag, which it clears with a one-cycle pulse. The point at which the flag rises depends on the mode. In Mode 0 it rises when the last data bit ends. In the asynchronous modes it rises as the stop bit begins. This gives software a full stop-bit time to prepare the next byte.

Top module: `ser9_tx`

## Requirements
- R1: In modes 01, 10 and 11 the frame is a low start bit, then the data bits least significant first, then an optional ninth bit, then one high stop bit. Every bit lasts one bit period. When not busy, ser_out is high.
- R2: In modes 10 and 11 the value of ninth_bit captured at the write is sent as a tenth bit, between the last data bit and the stop bit. In mode 01 no ninth bit is sent and the stop bit follows the data directly.
- R3: In mode 00 the eight data bits leave least significant first, each for 12 clock cycles. Within each bit, shift_clk is low for the first 6 cycles and high for the last 6. shift_clk is high whenever mode 00 is not transmitting.
- R4: In mode 10 a bit lasts 64 clock cycles, or 32 when rate_dbl was high at the write.
- R5: In modes 01 and 11 each bit ends on the clock edge at which rate_tick is high. rate_tick has no effect while idle, and none in modes 00 and 10.
- R6: In mode 00, tx_done rises on the same edge at which the eighth bit ends and busy falls.
- R7: In modes 01, 10 and 11, tx_done rises on the edge at which the stop bit starts. The stop bit then lasts one full bit period before busy falls.
- R8: tx_done stays high until a done_clr pulse. It is low on the cycle after done_clr. If a set and a clear fall in the same cycle, the set wins.
- R9: A write while busy is ignored. Changes to mode, ninth_bit, rate_dbl or wr_data during a frame do not change that frame.
- R10: After reset, ser_out and shift_clk are high, and busy and tx_done are low.
- R11: busy is high from the cycle after an accepted write until the end of the last bit of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle write strobe; accepted only when not busy |
| wr_data | input | DATA_W | Byte to send |
| mode | input | 2 | 00 shift, 01 async 8-bit, 10 async 9-bit fixed rate, 11 async 9-bit variable rate |
| ninth_bit | input | 1 | Value of the ninth bit for modes 10 and 11 |
| rate_dbl | input | 1 | Selects divide-by-32 instead of divide-by-64 in mode 10 |
| rate_tick | input | 1 | External bit-rate pulse for modes 01 and 11 |
| done_clr | input | 1 | Clears tx_done |
| ser_out | output | 1 | Serial data line, idles high |
| shift_clk | output | 1 | Shift clock for mode 00, idles high |
| busy | output | 1 | A frame is in progress |
| tx_done | output | 1 | Sticky transmit-complete flag |

## Verification
The bench compares the line, shift clock, busy and flag on every cycle of each frame against a model built from the mode, the data and the bit period. A design that ran the flag on the Mode 0 rule in the asynchronous modes, or the other way round, would have the flag rise one bit period early or late. A design that sent the ninth bit in Mode 1 would pull the line low where the stop bit should be. A design that ignored the rate-double input, or let the external tick pace Modes 0 and 2, would drift out of bit alignment. The bench also writes a second byte partway through a frame, with a different mode, ninth bit and rate bit. A design that restarted or picked up the new settings would corrupt the rest of the frame.

// File: rtl/ser9_tx_pkg.sv
package ser9_tx_pkg;

   typedef enum logic [1:0] {
      TXM_SHIFT      = 2'b00,
      TXM_ASYNC8     = 2'b01,
      TXM_ASYNC9_FIX = 2'b10,
      TXM_ASYNC9_VAR = 2'b11
   } txmode_e;

   // modes whose bit period comes from the external tick
   function automatic logic uses_ext_rate(input txmode_e m);
      return (m == TXM_ASYNC8) || (m == TXM_ASYNC9_VAR);
   endfunction

   // modes that append the software ninth bit
   function automatic logic has_ninth(input txmode_e m);
      return (m == TXM_ASYNC9_FIX) || (m == TXM_ASYNC9_VAR);
   endfunction

endpackage

// File: rtl/ser9_tx_baud.sv
module ser9_tx_baud
   import ser9_tx_pkg::*;
#(
   parameter int SHIFT_DIV = 12,
   parameter int FIX_DIV   = 64
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    restart,
   input  logic    run,
   input  txmode_e mode,
   input  logic    dbl,
   input  logic    rate_tick,
   output logic    bit_end,
   output logic    sclk_low
);

   localparam int CW = $clog2(FIX_DIV);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim_m1;
   logic          ext;

   always_comb begin
      case (mode)
         TXM_SHIFT:      lim_m1 = CW'(SHIFT_DIV - 1);
         TXM_ASYNC9_FIX: lim_m1 = dbl ? CW'(FIX_DIV / 2 - 1) : CW'(FIX_DIV - 1);
         default:        lim_m1 = '0;
      endcase
   end

   assign ext     = uses_ext_rate(mode);
   assign bit_end = run && (ext ? rate_tick : (cnt == lim_m1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (restart || !run || ext)  cnt <= '0;
      else if (cnt == lim_m1)           cnt <= '0;
      else                              cnt <= cnt + 1'b1;
   end

   assign sclk_low = run && (mode == TXM_SHIFT) && (cnt < CW'(SHIFT_DIV / 2));

   // R4
   cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run && !ext && !restart |-> cnt <= lim_m1);

endmodule

// File: rtl/ser9_tx_frame.sv
module ser9_tx_frame
   import ser9_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  txmode_e           mode_in,
   input  logic              ninth_in,
   input  logic              dbl_in,
   input  logic              bit_end,
   output logic              busy,
   output logic              start,
   output txmode_e           mode_q,
   output logic              dbl_q,
   output logic              ser_out,
   output logic              done_set
);

   localparam int FW = DATA_W + 3;
   localparam int LW = $clog2(FW + 1);

   logic [FW-1:0] sh;
   logic [FW-1:0] load_v;
   logic [LW-1:0] left;
   logic [LW-1:0] load_n;

   assign start = wr_en && !busy;

   always_comb begin
      load_v = '1;
      case (mode_in)
         TXM_SHIFT: begin
            load_v[DATA_W-1:0] = wr_data;
            load_n             = LW'(DATA_W);
         end
         TXM_ASYNC8: begin
            load_v[0]        = 1'b0;
            load_v[DATA_W:1] = wr_data;
            load_n           = LW'(DATA_W + 2);
         end
         default: begin
            load_v[0]          = 1'b0;
            load_v[DATA_W:1]   = wr_data;
            load_v[DATA_W+1]   = has_ninth(mode_in) ? ninth_in : 1'b1;
            load_n             = LW'(DATA_W + 3);
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sh     <= '1;
         left   <= '0;
         mode_q <= TXM_SHIFT;
         dbl_q  <= 1'b0;
      end else if (start) begin
         busy   <= 1'b1;
         sh     <= load_v;
         left   <= load_n;
         mode_q <= mode_in;
         dbl_q  <= dbl_in;
      end else if (bit_end) begin
         sh   <= {1'b1, sh[FW-1:1]};
         left <= left - 1'b1;
         if (left == LW'(1)) busy <= 1'b0;
      end
   end

   assign ser_out  = busy ? sh[0] : 1'b1;
   assign done_set = bit_end &&
                     ((mode_q == TXM_SHIFT) ? (left == LW'(1)) : (left == LW'(2)));

   // R11
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   // R9
   busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && wr_en |=> $stable(mode_q) && $stable(dbl_q));

   // R7
   stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_set && (mode_q != TXM_SHIFT) |=> busy && ser_out);

   // R6
   shift_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_set && (mode_q == TXM_SHIFT) |=> !busy);

endmodule

// File: rtl/ser9_tx_flag.sv
module ser9_tx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !clr |=> flag);

endmodule

// File: rtl/ser9_tx.sv
module ser9_tx
   import ser9_tx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SHIFT_DIV = 12,
   parameter int FIX_DIV   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        mode,
   input  logic              ninth_bit,
   input  logic              rate_dbl,
   input  logic              rate_tick,
   input  logic              done_clr,
   output logic              ser_out,
   output logic              shift_clk,
   output logic              busy,
   output logic              tx_done
);

   generate
      if (DATA_W < 1)
         $error("ser9_tx: DATA_W must be at least 1");
      if ((SHIFT_DIV < 2) || (SHIFT_DIV % 2 != 0))
         $error("ser9_tx: SHIFT_DIV must be even and at least 2");
      if ((FIX_DIV < 4) || (FIX_DIV % 2 != 0) || (SHIFT_DIV > FIX_DIV))
         $error("ser9_tx: FIX_DIV must be even, at least 4 and not below SHIFT_DIV");
   endgenerate

   logic    start, bit_end, sclk_low, done_set, dbl_q;
   txmode_e mode_q;

   ser9_tx_frame #(.DATA_W(DATA_W)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .mode_in  (txmode_e'(mode)),
      .ninth_in (ninth_bit),
      .dbl_in   (rate_dbl),
      .bit_end  (bit_end),
      .busy     (busy),
      .start    (start),
      .mode_q   (mode_q),
      .dbl_q    (dbl_q),
      .ser_out  (ser_out),
      .done_set (done_set)
   );

   ser9_tx_baud #(.SHIFT_DIV(SHIFT_DIV), .FIX_DIV(FIX_DIV)) u_baud (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (start),
      .run       (busy),
      .mode      (mode_q),
      .dbl       (dbl_q),
      .rate_tick (rate_tick),
      .bit_end   (bit_end),
      .sclk_low  (sclk_low)
   );

   ser9_tx_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (done_set),
      .clr   (done_clr),
      .flag  (tx_done)
   );

   assign shift_clk = !sclk_low;

   // R1
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ser_out && shift_clk);

   // R3
   sclk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_clk |-> busy && (mode_q == TXM_SHIFT));

   // R7
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_done) |-> $past(busy));

endmodule

// File: tb/ser9_tx_bench.sv
`timescale 1ns/1ps
module ser9_tx_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] mode = 2'b00;
   logic       ninth_bit = 1'b0;
   logic       rate_dbl = 1'b0;
   logic       rate_tick = 1'b0;
   logic       done_clr = 1'b0;
   logic       ser_out, shift_clk, busy, tx_done;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   ser9_tx u_ser9_tx (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
      .ninth_bit(ninth_bit), .rate_dbl(rate_dbl), .rate_tick(rate_tick),
      .done_clr(done_clr), .ser_out(ser_out), .shift_clk(shift_clk),
      .busy(busy), .tx_done(tx_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Sends one frame and compares every cycle against a model.
   task automatic run_frame(input logic [1:0] md, input logic [7:0] d, input logic b9,
                            input logic dbl, input int tper, input bit intrude,
                            input bit noise, input string req);
      int per, nb, el, eb, ed, ec, first_bad;
      logic [10:0] fr;
      logic exp_line, exp_busy, exp_done, exp_clk;
      per = (md == 2'b00) ? 12 : (md == 2'b10) ? (dbl ? 32 : 64) : tper;
      nb  = (md == 2'b00) ? 8 : (md == 2'b01) ? 10 : 11;
      fr  = (md == 2'b00) ? {3'b111, d} : (md == 2'b01) ? {2'b11, d, 1'b0} : {1'b1, b9, d, 1'b0};
      el = 0; eb = 0; ed = 0; ec = 0; first_bad = -1;
      @(negedge clk);
      wr_en = 1'b1; wr_data = d; mode = md; ninth_bit = b9; rate_dbl = dbl; rate_tick = 1'b0;
      for (int n = 0; n <= nb * per + 2; n++) begin
         int b;
         @(negedge clk);
         b = n / per;
         exp_busy = (b < nb);
         exp_line = exp_busy ? fr[b] : 1'b1;
         exp_done = (md == 2'b00) ? (b >= nb) : (b >= nb - 1);
         exp_clk  = (exp_busy && md == 2'b00) ? ((n % per) >= per / 2) : 1'b1;
         if (ser_out !== exp_line) begin el++; if (first_bad < 0) first_bad = n; end
         if (busy !== exp_busy) eb++;
         if (tx_done !== exp_done) ed++;
         if (shift_clk !== exp_clk) ec++;
         wr_en = 1'b0;
         if (intrude && n == 3 * per) begin
            wr_en = 1'b1; wr_data = ~d; mode = md ^ 2'b10; ninth_bit = ~b9; rate_dbl = ~dbl;
         end
         if (md[0]) rate_tick = ((n + 1) % per == 0);
         else       rate_tick = noise ? (n % 5 == 0) : 1'b0;
      end
      rate_tick = 1'b0; wr_en = 1'b0;
      check(el == 0, req, $sformatf("line bit mismatches (first at cycle %0d)", first_bad), el, 0);
      check(eb == 0, "R11", "busy mismatches", eb, 0);
      check(ed == 0, (md == 2'b00) ? "R6" : "R7", "tx_done timing mismatches", ed, 0);
      check(ec == 0, "R3", "shift_clk mismatches", ec, 0);
      // R8: flag is sticky, then cleared by done_clr
      repeat (5) @(negedge clk);
      check(tx_done === 1'b1, "R8", "tx_done held before clear", tx_done, 1);
      done_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0;
      check(tx_done === 1'b0, "R8", "tx_done after clear", tx_done, 0);
   endtask

   task automatic t_reset();
      check(ser_out === 1'b1, "R10", "ser_out in reset", ser_out, 1);
      check(shift_clk === 1'b1, "R10", "shift_clk in reset", shift_clk, 1);
      check(busy === 1'b0, "R10", "busy in reset", busy, 0);
      check(tx_done === 1'b0, "R10", "tx_done in reset", tx_done, 0);
   endtask

   task automatic t_idle_tick();
      int errs = 0;
      mode = 2'b11;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         rate_tick = (i % 3 == 0);
         if (ser_out !== 1'b1 || busy !== 1'b0 || tx_done !== 1'b0) errs++;
      end
      rate_tick = 1'b0;
      check(errs == 0, "R5", "idle outputs disturbed by rate_tick", errs, 0);
   endtask

   task automatic t_shift_mode();   run_frame(2'b00, 8'hA5, 1'b1, 1'b0, 0, 1'b0, 1'b1, "R3"); endtask
   task automatic t_async8();       run_frame(2'b01, 8'h3C, 1'b0, 1'b0, 16, 1'b0, 1'b0, "R2"); endtask
   task automatic t_async9_fix();   run_frame(2'b10, 8'h96, 1'b1, 1'b0, 0, 1'b0, 1'b1, "R4"); endtask
   task automatic t_async9_dbl();   run_frame(2'b10, 8'h5A, 1'b0, 1'b1, 0, 1'b0, 1'b0, "R4"); endtask
   task automatic t_async9_var();   run_frame(2'b11, 8'hC3, 1'b1, 1'b0, 7, 1'b0, 1'b0, "R5"); endtask
   task automatic t_async9_var_b0(); run_frame(2'b11, 8'h0F, 1'b0, 1'b0, 9, 1'b0, 1'b0, "R1"); endtask
   task automatic t_busy_write();   run_frame(2'b01, 8'h81, 1'b1, 1'b0, 10, 1'b1, 1'b0, "R9"); endtask
   task automatic t_shift_busy();   run_frame(2'b00, 8'h6E, 1'b0, 1'b1, 0, 1'b1, 1'b0, "R9"); endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_idle_tick();
      t_shift_mode();
      t_async8();
      t_async9_fix();
      t_async9_dbl();
      t_async9_var();
      t_async9_var_b0();
      t_busy_write();
      t_shift_busy();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule